// File: doc/BRIEF.md
# Indirect 16-bit processor register bridge

This block lets a host that can only issue byte-wide register accesses reach the 16-bit address and data space of an embedded processor. A serial front end decodes each host byte access and hands it to the bridge as a write strobe or a read strobe, tagged with an 8-bit sub-address. Three sub-addresses act as windows: one loads a processor address for a write, one loads a processor address for a read, and one carries the 16-bit data. A fourth sub-address is a status byte.

Each window assembles two byte accesses into one 16-bit value, high byte first. When the pair is complete, the bridge raises a request towards the processor and holds it with stable address and data until the processor acknowledges. From the request until the acknowledge, the bridge reports busy, and it drives a not-ready output that the serial front end uses to stretch the transfer. The processor may take tens of milliseconds to answer, so busy has no timeout. Window accesses made while busy do nothing except set a sticky error flag. Every new serial transfer returns all windows to the high-byte phase, so a half-loaded pair is thrown away.

Top module: `pbr_bridge`

## Requirements
- R1: Two writes to the write-address window (sub-address 0x20, high then low) arm a write address. Two writes to the data window (0x22, high then low) then raise `preq_o` with `pwe_o`=1 and the assembled `paddr_o` and `pwdata_o`. This happens on the clock edge that samples the low data byte.
- R2: Two writes to the read-address window (0x21, high then low) raise `preq_o` with `pwe_o`=0 and the assembled `paddr_o`. `prdata_i` is latched on the acknowledge edge. Later reads of the data window return its high byte and then its low byte.
- R3: A read of the status byte (0x23) returns bit 0 = busy and bit 1 = sticky error, with all other bits 0. Every read returns its byte on `rdata_o` from the clock edge that samples the strobe.
- R4: Busy and `hold_o` are set from the edge that raises a request until the edge that samples `pack_i`. There is no upper limit on this time.
- R5: While `pack_i` is low, `preq_o`, `pwe_o`, `paddr_o` and `pwdata_o` stay unchanged. `preq_o` and `hold_o` are low in the cycle after the acknowledge.
- R6: A pulse on `xfer_start_i` returns every window to the high-byte phase, which discards a partial pair. If `xfer_start_i` and a strobe fall in the same cycle, that strobe counts as a high byte.
- R7: A write to any window while busy is ignored: no request is raised, the byte phase does not advance, and the armed address is not changed. The write also sets the sticky error bit. This includes a write in the cycle in which `pack_i` arrives.
- R8: A read of the data window while busy leaves `rdata_o` at its previous value, does not advance the phase, and sets the sticky error bit.
- R9: A status read returns the sticky error bit and clears it, so the next status read shows 0 in bit 1.
- R10: A low data byte issues no request unless a write address is armed. Issuing a write request disarms the write address.
- R11: After reset, `preq_o`, `hold_o` and `rdata_o` are 0, and a status read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xfer_start_i | input | 1 | Pulse at the start of each serial transfer |
| wr_stb_i | input | 1 | Host byte write strobe |
| rd_stb_i | input | 1 | Host byte read strobe |
| sub_addr_i | input | 8 | Sub-address of the byte access |
| wdata_i | input | 8 | Byte written by the host |
| rdata_o | output | 8 | Byte returned to the host |
| hold_o | output | 1 | Not-ready; the front end stretches the transfer |
| preq_o | output | 1 | Request to the processor |
| pwe_o | output | 1 | 1 = write request, 0 = read request |
| paddr_o | output | 16 | Processor address |
| pwdata_o | output | 16 | Processor write data |
| pack_i | input | 1 | Processor acknowledge, one cycle |
| prdata_i | input | 16 | Processor read data, valid with `pack_i` |

## Verification
The processor acknowledge that clears busy can arrive in the same cycle as a host window access. The bench provokes this by driving `pack_i` and a write-address strobe in the same cycle. It then expects the byte to be rejected, with the sticky error bit read back set and busy read back clear. A second collision puts `xfer_start_i` on the same cycle as a window strobe. That strobe is judged to act as a high byte by the address that the next request carries. Expected addresses, data and read bytes all come from arithmetic sweeps over the address and data space, with acknowledge latencies that vary from zero up to thousands of cycles.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR
  } req_st_e;

  localparam int WIN_WADDR = 0;
  localparam int WIN_RADDR = 1;
  localparam int WIN_DATA  = 2;
  localparam int NUM_WIN   = 3;
endpackage

// File: rtl/pbr_pair_asm.sv
// High/low byte pair assembler with a phase toggle.
module pbr_pair_asm #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [BW-1:0] byte_i,
  output logic [BW-1:0] hi_o,
  output logic          done_o
);
  logic          phase_q;
  logic          phase_eff;
  logic [BW-1:0] hi_q;

  // a transfer start in the same cycle wins over the stored phase
  assign phase_eff = clr_i ? 1'b0 : phase_q;
  assign done_o    = step_i & phase_eff;
  assign hi_o      = hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      phase_q <= step_i ? ~phase_eff : phase_eff;
      if (step_i && !phase_eff) hi_q <= byte_i;
    end
  end
endmodule

// File: rtl/pbr_req_ctrl.sv
// Request/acknowledge sequencer towards the processor.
module pbr_req_ctrl
  import pbr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_go_i,
  input  logic          wr_go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pack_i,
  input  logic [DW-1:0] prdata_i,
  output logic          preq_o,
  output logic          pwe_o,
  output logic [AW-1:0] paddr_o,
  output logic [DW-1:0] pwdata_o,
  output logic          busy_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rd_data_o
);
  req_st_e       st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (wr_go_i) begin
            st_q    <= ST_WR;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
          end else if (rd_go_i) begin
            st_q   <= ST_RD;
            addr_q <= addr_i;
          end
        end
        ST_RD, ST_WR: if (pack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign preq_o    = (st_q != ST_IDLE);
  assign pwe_o     = (st_q == ST_WR);
  assign paddr_o   = addr_q;
  assign pwdata_o  = wdata_q;
  assign busy_o    = preq_o;
  assign rd_done_o = (st_q == ST_RD) && pack_i;
  assign rd_data_o = prdata_i;
endmodule

// File: rtl/pbr_bridge.sv
module pbr_bridge
  import pbr_pkg::*;
#(
  parameter int          BW        = 8,
  parameter logic [7:0]  SUB_WADDR = 8'h20,
  parameter logic [7:0]  SUB_RADDR = 8'h21,
  parameter logic [7:0]  SUB_DATA  = 8'h22,
  parameter logic [7:0]  SUB_STAT  = 8'h23
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xfer_start_i,
  input  logic            wr_stb_i,
  input  logic            rd_stb_i,
  input  logic [7:0]      sub_addr_i,
  input  logic [BW-1:0]   wdata_i,
  output logic [BW-1:0]   rdata_o,
  output logic            hold_o,
  output logic            preq_o,
  output logic            pwe_o,
  output logic [2*BW-1:0] paddr_o,
  output logic [2*BW-1:0] pwdata_o,
  input  logic            pack_i,
  input  logic [2*BW-1:0] prdata_i
);
  localparam int WW = 2 * BW;
  localparam logic [8*NUM_WIN-1:0] SUB_VEC = {SUB_DATA, SUB_RADDR, SUB_WADDR};

  logic [NUM_WIN-1:0] hit;
  logic [NUM_WIN-1:0] step_w;
  logic [NUM_WIN-1:0] done_w;
  logic [BW-1:0]      hi_w [NUM_WIN];

  logic          busy;
  logic          hit_stat;
  logic          any_win_acc;
  logic          viol;
  logic          rd_go, wr_go;
  logic          rd_done;
  logic [WW-1:0] rd_data;
  logic [WW-1:0] req_addr;
  logic [WW-1:0] req_wdata;
  logic [WW-1:0] wa_q;
  logic [WW-1:0] rb_q;
  logic          armed_q;
  logic          err_q;
  logic [BW-1:0] rdata_q;
  logic [BW-1:0] rd_byte;

  assign hit_stat = (sub_addr_i == SUB_STAT);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit[w] = (sub_addr_i == SUB_VEC[8*w +: 8]);

    if (w == WIN_DATA) begin : g_rw
      assign step_w[w] = (wr_stb_i | rd_stb_i) & hit[w] & ~busy;
    end else begin : g_wo
      assign step_w[w] = wr_stb_i & hit[w] & ~busy;
    end

    pbr_pair_asm #(.BW(BW)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (xfer_start_i),
      .step_i (step_w[w]),
      .byte_i (wdata_i),
      .hi_o   (hi_w[w]),
      .done_o (done_w[w])
    );
  end

  assign any_win_acc = (wr_stb_i | rd_stb_i) & (|hit);
  assign viol        = any_win_acc & busy;

  assign rd_go     = done_w[WIN_RADDR];
  assign wr_go     = done_w[WIN_DATA] & wr_stb_i & armed_q;
  assign req_addr  = rd_go ? {hi_w[WIN_RADDR], wdata_i} : wa_q;
  assign req_wdata = {hi_w[WIN_DATA], wdata_i};

  pbr_req_ctrl #(.AW(WW), .DW(WW)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_go_i   (rd_go),
    .wr_go_i   (wr_go),
    .addr_i    (req_addr),
    .wdata_i   (req_wdata),
    .pack_i    (pack_i),
    .prdata_i  (prdata_i),
    .preq_o    (preq_o),
    .pwe_o     (pwe_o),
    .paddr_o   (paddr_o),
    .pwdata_o  (pwdata_o),
    .busy_o    (busy),
    .rd_done_o (rd_done),
    .rd_data_o (rd_data)
  );

  always_comb begin
    rd_byte = '0;
    if (hit_stat) begin
      rd_byte = {{(BW-2){1'b0}}, err_q, busy};
    end else if (hit[WIN_DATA]) begin
      if (busy) rd_byte = rdata_q;
      else      rd_byte = done_w[WIN_DATA] ? rb_q[BW-1:0] : rb_q[WW-1:BW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_q    <= '0;
      armed_q <= 1'b0;
      rb_q    <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (done_w[WIN_WADDR]) begin
        wa_q    <= {hi_w[WIN_WADDR], wdata_i};
        armed_q <= 1'b1;
      end else if (wr_go) begin
        armed_q <= 1'b0;
      end
      if (rd_done) rb_q <= rd_data;
      if (viol) err_q <= 1'b1;
      else if (rd_stb_i && hit_stat) err_q <= 1'b0;
      if (rd_stb_i) rdata_q <= rd_byte;
    end
  end

  assign rdata_o = rdata_q;
  assign hold_o  = busy;
endmodule

// File: rtl/pbr_bridge_chk.sv
module pbr_bridge_chk #(
  parameter int         BW       = 8,
  parameter logic [7:0] SUB_DATA = 8'h22
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rd_stb_i,
  input logic [7:0]      sub_addr_i,
  input logic [BW-1:0]   rdata_o,
  input logic            hold_o,
  input logic            preq_o,
  input logic            pwe_o,
  input logic [2*BW-1:0] paddr_o,
  input logic [2*BW-1:0] pwdata_o,
  input logic            pack_i
);
  p_busy_no_timeout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && !pack_i |=> hold_o);

  p_req_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preq_o && !pack_i |=> preq_o && $stable(pwe_o) && $stable(paddr_o) && $stable(pwdata_o));

  p_req_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preq_o && pack_i |=> !preq_o && !hold_o);

  p_busy_addr_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> $stable(paddr_o));

  p_busy_read_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o && rd_stb_i && (sub_addr_i == SUB_DATA) |=> $stable(rdata_o));
endmodule

bind pbr_bridge pbr_bridge_chk #(.BW(BW), .SUB_DATA(SUB_DATA)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_stb_i   (rd_stb_i),
  .sub_addr_i (sub_addr_i),
  .rdata_o    (rdata_o),
  .hold_o     (hold_o),
  .preq_o     (preq_o),
  .pwe_o      (pwe_o),
  .paddr_o    (paddr_o),
  .pwdata_o   (pwdata_o),
  .pack_i     (pack_i)
);

// File: tb/pbr_bridge_tb.sv
module pbr_bridge_tb;
  localparam logic [7:0] WA = 8'h20, RA = 8'h21, DW = 8'h22, ST = 8'h23;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_start_i = 1'b0;
  logic        wr_stb_i = 1'b0;
  logic        rd_stb_i = 1'b0;
  logic [7:0]  sub_addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        hold_o, preq_o, pwe_o;
  logic [15:0] paddr_o, pwdata_o;
  logic        pack_i = 1'b0;
  logic [15:0] prdata_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pbr_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_start_i(xfer_start_i),
    .wr_stb_i(wr_stb_i), .rd_stb_i(rd_stb_i), .sub_addr_i(sub_addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .hold_o(hold_o),
    .preq_o(preq_o), .pwe_o(pwe_o), .paddr_o(paddr_o), .pwdata_o(pwdata_o),
    .pack_i(pack_i), .prdata_i(prdata_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] sub, input logic [7:0] d, input bit st = 1'b0);
    wr_stb_i = 1'b1; sub_addr_i = sub; wdata_i = d; xfer_start_i = st;
    @(negedge clk);
    wr_stb_i = 1'b0; xfer_start_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] sub, output logic [7:0] d);
    rd_stb_i = 1'b1; sub_addr_i = sub;
    @(negedge clk);
    d = rdata_o;
    rd_stb_i = 1'b0;
  endtask

  task automatic serve(input int lat, input logic [15:0] rv);
    repeat (lat) @(negedge clk);
    pack_i = 1'b1; prdata_i = rv;
    @(negedge clk);
    pack_i = 1'b0; prdata_i = '0;
  endtask

  task automatic pulse_start();
    xfer_start_i = 1'b1;
    @(negedge clk);
    xfer_start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] a, d, v;

    repeat (3) @(negedge clk);
    chk("R11 preq", 32'(preq_o), 0);
    chk("R11 hold", 32'(hold_o), 0);
    chk("R11 rdata", 32'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(ST, b); chk("R11 status", 32'(b), 0);

    // write sweep
    for (int i = 0; i < 24; i++) begin
      a = 16'(i * 4099 + 17);
      d = 16'(i * 7919) ^ 16'h5a5a;
      pulse_start();
      wr(WA, a[15:8]); wr(WA, a[7:0]);
      chk("R10 no req after address", 32'(preq_o), 0);
      wr(DW, d[15:8]); wr(DW, d[7:0]);
      chk("R1 preq", 32'(preq_o), 1);
      chk("R1 pwe", 32'(pwe_o), 1);
      chk("R1 paddr", 32'(paddr_o), 32'(a));
      chk("R1 pwdata", 32'(pwdata_o), 32'(d));
      chk("R4 hold", 32'(hold_o), 1);
      rd(ST, b); chk("R3 status busy", 32'(b), 1);
      serve(i % 5, 16'h0);
      chk("R5 preq drop", 32'(preq_o), 0);
      chk("R5 hold drop", 32'(hold_o), 0);
      wr(DW, 8'h11); wr(DW, 8'h22);
      chk("R10 disarmed", 32'(preq_o), 0);
    end

    // read sweep
    for (int i = 0; i < 24; i++) begin
      a = 16'(i * 5821 + 3);
      v = a ^ 16'hc3a5;
      pulse_start();
      wr(RA, a[15:8]); wr(RA, a[7:0]);
      chk("R2 preq", 32'(preq_o), 1);
      chk("R2 pwe", 32'(pwe_o), 0);
      chk("R2 paddr", 32'(paddr_o), 32'(a));
      serve(i % 4, v);
      rd(DW, b); chk("R2 high byte", 32'(b), 32'(v[15:8]));
      rd(DW, b); chk("R2 low byte", 32'(b), 32'(v[7:0]));
      rd(ST, b); chk("R3 status idle", 32'(b), 0);
    end

    // R6: partial pairs discarded
    pulse_start();
    wr(WA, 8'hee);
    pulse_start();
    wr(WA, 8'h12); wr(WA, 8'h34);
    wr(DW, 8'hdd);
    pulse_start();
    wr(DW, 8'h56); wr(DW, 8'h78);
    chk("R6 paddr", 32'(paddr_o), 32'h1234);
    chk("R6 pwdata", 32'(pwdata_o), 32'h5678);
    serve(1, 16'h0);
    // R6: start in the same cycle as a strobe
    wr(RA, 8'h9a);
    wr(RA, 8'hab, 1'b1);
    wr(RA, 8'hcd);
    chk("R6 same-cycle start", 32'(paddr_o), 32'habcd);
    chk("R6 read req", 32'(preq_o), 1);
    serve(0, 16'h4321);

    // R7: window writes while busy are ignored
    pulse_start();
    wr(RA, 8'h0f); wr(RA, 8'hf0);
    wr(WA, 8'h77); wr(WA, 8'h88);
    wr(RA, 8'h99); wr(RA, 8'haa);
    chk("R7 paddr kept", 32'(paddr_o), 32'h0ff0);
    chk("R7 pwe kept", 32'(pwe_o), 0);
    serve(2, 16'hbeef);
    chk("R7 no new req", 32'(preq_o), 0);
    wr(DW, 8'h01); wr(DW, 8'h02);
    chk("R7 address not armed", 32'(preq_o), 0);
    rd(ST, b); chk("R9 error seen", 32'(b), 2);
    rd(ST, b); chk("R9 error cleared", 32'(b), 0);

    // R8: data read while busy
    pulse_start();
    rd(DW, b); chk("R8 high before", 32'(b), 32'h00be);
    wr(RA, 8'h40); wr(RA, 8'h41);
    rd(DW, b); chk("R8 busy read kept", 32'(b), 32'h00be);
    serve(1, 16'h6c93);
    rd(DW, b); chk("R8 phase kept", 32'(b), 32'h0093);
    rd(ST, b); chk("R8 error set", 32'(b), 2);
    rd(ST, b); chk("R9 cleared", 32'(b), 0);

    // collision: acknowledge and window write in one cycle
    pulse_start();
    wr(RA, 8'h50); wr(RA, 8'h51);
    pack_i = 1'b1; prdata_i = 16'ha1b2;
    wr_stb_i = 1'b1; sub_addr_i = WA; wdata_i = 8'h66;
    @(negedge clk);
    pack_i = 1'b0; wr_stb_i = 1'b0;
    chk("R7 collision busy clear", 32'(hold_o), 0);
    rd(ST, b); chk("R7 collision error", 32'(b), 2);
    wr(WA, 8'h61); wr(WA, 8'h62);
    wr(DW, 8'h63); wr(DW, 8'h64);
    chk("R7 collision phase kept", 32'(paddr_o), 32'h6162);
    serve(0, 16'h0);

    // R4: very long busy
    pulse_start();
    wr(WA, 8'h7e); wr(WA, 8'h7f);
    wr(DW, 8'h01); wr(DW, 8'h02);
    repeat (3000) @(negedge clk);
    chk("R4 long hold", 32'(hold_o), 1);
    rd(ST, b); chk("R4 long status", 32'(b), 1);
    repeat (3000) @(negedge clk);
    chk("R4 long preq", 32'(preq_o), 1);
    serve(0, 16'h0);
    chk("R4 released", 32'(hold_o), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule